// File: doc/BRIEF.md
# LSTM Gate Activation and State Update

This block closes one LSTM time step for one layer. The accumulator in front of it delivers four pre-activation values for one hidden element at a time: input gate, forget gate, output gate and candidate. Each element arrives with its layer number and element index under a valid strobe. The block squashes the three gates with a piecewise-linear sigmoid and clamps the candidate with a piecewise-linear tanh. It then folds them into that element's stored cell value and produces the new cell and hidden values. All arithmetic is signed 16-bit fixed point with 12 fractional bits (Q4.12), so 1.0 is 0x1000.

Cell and hidden state live inside the block, one slot per layer and element, and persist from one time step to the next. The new hidden element is streamed out beside the cell value. Any stored hidden element can also be read through a separate combinational read port, which lets the next layer or the next step fetch it. An init pulse clears all state at the start of a sequence. A done pulse marks the final element of the final layer in the last step of a fixed-length sequence.

Top module: `lstm_gate_update`

## Requirements
- R1: Each of the three gates maps to clamp((x >>> 2) + 0x0800, 0x0000, 0x1000). Any x at or below -8192 gives 0 and any x at or above 8192 gives 0x1000.
- R2: The candidate maps to clamp(x, 0xF000, 0x1000), so it is limited to the range -1.0 to +1.0. The same clamp is applied to the new cell value before the hidden value is formed.
- R3: The new cell value is (f*c_old >>> 12) + (i*g >>> 12). Here c_old is the stored cell value for the same layer and element, and each shift is arithmetic, so it rounds toward minus infinity.
- R4: The new hidden value is o * clamp(c_new) >>> 12. It is presented on `out_h`, with `c_new` on `out_c`.
- R5: Every product and the cell sum saturate to the range 0x8000..0x7FFF instead of wrapping.
- R6: Suppose an element is accepted at a rising edge with `in_valid` high and `init` low. Its results appear, with `out_valid` high and its layer and index, after the next rising edge and not earlier. One element per cycle is sustained.
- R7: State is kept separately for each layer and element and persists between updates. `rd_h` returns the stored hidden value at {`rd_layer`,`rd_idx`} combinationally.
- R8: While `init` is high at a rising edge, all cell and hidden state becomes zero. The element offered in that cycle is discarded, the element already in flight is discarded, and the step count restarts.
- R9: Two consecutive updates of the same layer and element chain correctly. The second update uses the cell value the first one produced, and the old value stays readable until the update that replaces it.
- R10: `seq_done` pulses together with the output of element HIDDEN-1 of layer NUM_LAYERS-1 in the 50th step (SEQ_LEN) counted since init. The count then restarts.
- R11: While `rst_n` is low at a rising edge, `out_valid` and `seq_done` go low and all state becomes zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| init | input | 1 | Sequence start: clears state and step count |
| in_valid | input | 1 | Pre-activation element valid |
| in_layer | input | 1 | Layer of the element |
| in_idx | input | 5 | Hidden element index |
| pre_i | input | 16 | Input gate pre-activation, Q4.12 |
| pre_f | input | 16 | Forget gate pre-activation, Q4.12 |
| pre_o | input | 16 | Output gate pre-activation, Q4.12 |
| pre_g | input | 16 | Candidate pre-activation, Q4.12 |
| rd_layer | input | 1 | Hidden read port layer |
| rd_idx | input | 5 | Hidden read port element |
| rd_h | output | 16 | Stored hidden value at the read address |
| out_valid | output | 1 | Result valid |
| out_layer | output | 1 | Layer of the result |
| out_idx | output | 5 | Element index of the result |
| out_c | output | 16 | New cell value, Q4.12 |
| out_h | output | 16 | New hidden value, Q4.12 |
| seq_done | output | 1 | Last element of the last step |

## Verification
A sequence-start pulse and an element update can fall in the same cycle. This happens either when an element is offered with `init` high, or when `init` arrives while the previous element sits between the activation and update stages. The bench provokes both cases. In each case it judges that no result emerges and that the read port then returns zero for the slots those elements and earlier updates had touched. It also places an init between one last-element update and a full 50-step stream. The done pulse must then land on exactly the 3200th result, which shows that the step count was restarted.

// File: rtl/lstm_gu_pkg.sv
// Package: Q4.12 fixed-point type, constants and saturating arithmetic
// shared by the gate activation / state update block.
// Assumes signed 16-bit data with 12 fractional bits throughout.
package lstm_gu_pkg;

    localparam int DATA_W = 16;
    localparam int FRAC   = 12;

    typedef logic signed [DATA_W-1:0] q412_t;

    localparam q412_t Q_ONE     = 16'sh1000;
    localparam q412_t Q_HALF    = 16'sh0800;
    localparam q412_t Q_NEG_ONE = -16'sh1000;
    localparam q412_t Q_MAX     = 16'sh7FFF;
    localparam q412_t Q_MIN     = -16'sh8000;

    // gate slot numbering inside the per-element activation vector
    localparam int G_IN   = 0;
    localparam int G_FGT  = 1;
    localparam int G_OUT  = 2;
    localparam int G_CAND = 3;
    localparam int N_GATE = 4;

    // clamp a wide signed value to the 16-bit range
    function automatic q412_t sat16(input logic signed [31:0] v);
        if (v > 32'sd32767)       return Q_MAX;
        else if (v < -32'sd32768) return Q_MIN;
        else                      return v[DATA_W-1:0];
    endfunction

    // Q4.12 multiply with floor rescale and saturation
    function automatic q412_t qmul(input q412_t a, input q412_t b);
        logic signed [31:0] p;
        p = 32'(a) * 32'(b);
        return sat16(p >>> FRAC);
    endfunction

    // Q4.12 saturating add
    function automatic q412_t qadd(input q412_t a, input q412_t b);
        logic signed [DATA_W:0] s;
        s = {a[DATA_W-1], a} + {b[DATA_W-1], b};
        return sat16(32'(s));
    endfunction

endpackage

// File: rtl/lstm_hard_act.sv
// Piecewise-linear activation in Q4.12.
// TANH=0: clamp(x/4 + 0.5, 0, 1); TANH=1: clamp(x, -1, +1).
// Purely combinational; assumes arithmetic shift is acceptable as x/4.
module lstm_hard_act
    import lstm_gu_pkg::*;
#(
    parameter bit TANH = 1'b0
) (
    input  q412_t x,
    output q412_t y
);

    generate
        if (TANH) begin : g_tanh
            // clamp the input into the unit band
            always_comb begin
                if (x > Q_ONE)          y = Q_ONE;
                else if (x < Q_NEG_ONE) y = Q_NEG_ONE;
                else                    y = x;
            end
        end else begin : g_sig
            q412_t lin;
            // scaled and offset line, then clamp to [0, 1]
            always_comb begin
                lin = (x >>> 2) + Q_HALF;
                if (lin > Q_ONE)      y = Q_ONE;
                else if (lin < 16'sd0) y = '0;
                else                  y = lin;
            end
        end
    endgenerate

endmodule

// File: rtl/lstm_state_mem.sv
// Cell and hidden state storage, one slot per {layer, element}.
// One write port (both values), one cell read port for the update path,
// one hidden read port for the consumer. Reads are combinational and
// return the pre-write value in a write cycle. Assumes HIDDEN is a power of two.
module lstm_state_mem
    import lstm_gu_pkg::*;
#(
    parameter int HIDDEN     = 32,
    parameter int NUM_LAYERS = 2,
    localparam int IDX_W   = $clog2(HIDDEN),
    localparam int LAYER_W = (NUM_LAYERS > 1) ? $clog2(NUM_LAYERS) : 1,
    localparam int DEPTH   = NUM_LAYERS * HIDDEN
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               wr_en,
    input  logic [LAYER_W-1:0] wr_layer,
    input  logic [IDX_W-1:0]   wr_idx,
    input  q412_t              wr_c,
    input  q412_t              wr_h,
    input  logic [LAYER_W-1:0] rc_layer,
    input  logic [IDX_W-1:0]   rc_idx,
    output q412_t              rc_c,
    input  logic [LAYER_W-1:0] rh_layer,
    input  logic [IDX_W-1:0]   rh_idx,
    output q412_t              rh_h
);

    localparam int ADDR_W = LAYER_W + IDX_W;

    q412_t c_mem [DEPTH];
    q412_t h_mem [DEPTH];

    logic [ADDR_W-1:0] wa, rca, rha;
    assign wa  = {wr_layer, wr_idx};
    assign rca = {rc_layer, rc_idx};
    assign rha = {rh_layer, rh_idx};

    // clear on reset or init, otherwise write one slot
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int k = 0; k < DEPTH; k++) begin
                c_mem[k] <= '0;
                h_mem[k] <= '0;
            end
        end else if (wr_en) begin
            c_mem[wa] <= wr_c;
            h_mem[wa] <= wr_h;
        end
    end

    // asynchronous read ports
    assign rc_c = c_mem[rca];
    assign rh_h = h_mem[rha];

endmodule

// File: rtl/lstm_cell_calc.sv
// Combinational state update for one element:
// c_new = f*c_old + i*g, h_new = o*clamp(c_new), all saturating Q4.12.
// Assumes gate inputs are already activated.
module lstm_cell_calc
    import lstm_gu_pkg::*;
(
    input  q412_t a_in,
    input  q412_t a_fgt,
    input  q412_t a_out,
    input  q412_t a_cand,
    input  q412_t c_old,
    output q412_t c_new,
    output q412_t h_new
);

    q412_t keep_term, add_term, c_clamp;

    // forget-scaled old state plus gated candidate
    always_comb begin
        keep_term = qmul(a_fgt, c_old);
        add_term  = qmul(a_in, a_cand);
        c_new     = qadd(keep_term, add_term);
    end

    lstm_hard_act #(.TANH(1'b1)) u_cclamp (
        .x (c_new),
        .y (c_clamp)
    );

    // output-gated squashed cell
    always_comb h_new = qmul(a_out, c_clamp);

endmodule

// File: rtl/lstm_gate_update.sv
// Top: LSTM gate activation and state update, two-stage pipeline.
// Stage A activates the four pre-activations and fetches the old cell value
// (forwarded from stage A when the same slot is updated back to back).
// Stage B computes the new state, writes it to storage and presents it.
// Assumes HIDDEN is a power of two; init has priority over any element.
module lstm_gate_update
    import lstm_gu_pkg::*;
#(
    parameter int HIDDEN     = 32,
    parameter int NUM_LAYERS = 2,
    parameter int SEQ_LEN    = 50,
    localparam int IDX_W   = $clog2(HIDDEN),
    localparam int LAYER_W = (NUM_LAYERS > 1) ? $clog2(NUM_LAYERS) : 1,
    localparam int STEP_W  = $clog2(SEQ_LEN + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                init,
    input  logic                in_valid,
    input  logic [LAYER_W-1:0]  in_layer,
    input  logic [IDX_W-1:0]    in_idx,
    input  logic signed [15:0]  pre_i,
    input  logic signed [15:0]  pre_f,
    input  logic signed [15:0]  pre_o,
    input  logic signed [15:0]  pre_g,
    input  logic [LAYER_W-1:0]  rd_layer,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic signed [15:0]  rd_h,
    output logic                out_valid,
    output logic [LAYER_W-1:0]  out_layer,
    output logic [IDX_W-1:0]    out_idx,
    output logic signed [15:0]  out_c,
    output logic signed [15:0]  out_h,
    output logic                seq_done
);

    localparam logic [IDX_W-1:0]   LAST_IDX   = IDX_W'(HIDDEN - 1);
    localparam logic [LAYER_W-1:0] LAST_LAYER = LAYER_W'(NUM_LAYERS - 1);
    localparam logic [STEP_W-1:0]  LAST_STEP  = STEP_W'(SEQ_LEN - 1);

    // ---------------- stage A: activation ----------------
    q412_t pre_v [N_GATE];
    q412_t act_v [N_GATE];

    assign pre_v[G_IN]   = pre_i;
    assign pre_v[G_FGT]  = pre_f;
    assign pre_v[G_OUT]  = pre_o;
    assign pre_v[G_CAND] = pre_g;

    for (genvar g = 0; g < N_GATE; g++) begin : g_act
        lstm_hard_act #(.TANH(g == G_CAND)) u_act (
            .x (pre_v[g]),
            .y (act_v[g])
        );
    end

    logic               a_valid;
    logic [LAYER_W-1:0] a_layer;
    logic [IDX_W-1:0]   a_idx;
    q412_t              a_act [N_GATE];
    q412_t              a_cold;

    q412_t mem_c, calc_c, calc_h, c_fetch;
    logic  fwd_hit;

    // same slot held in stage A: take its fresh result instead of storage
    assign fwd_hit = a_valid && (a_layer == in_layer) && (a_idx == in_idx);
    assign c_fetch = fwd_hit ? calc_c : mem_c;

    // stage A register: activated gates, old cell value, tag
    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            a_valid <= 1'b0;
            a_layer <= '0;
            a_idx   <= '0;
            a_cold  <= '0;
            for (int k = 0; k < N_GATE; k++) a_act[k] <= '0;
        end else begin
            a_valid <= in_valid;
            if (in_valid) begin
                a_layer <= in_layer;
                a_idx   <= in_idx;
                a_cold  <= c_fetch;
                for (int k = 0; k < N_GATE; k++) a_act[k] <= act_v[k];
            end
        end
    end

    // ---------------- stage B: state update ----------------
    lstm_cell_calc u_calc (
        .a_in   (a_act[G_IN]),
        .a_fgt  (a_act[G_FGT]),
        .a_out  (a_act[G_OUT]),
        .a_cand (a_act[G_CAND]),
        .c_old  (a_cold),
        .c_new  (calc_c),
        .h_new  (calc_h)
    );

    lstm_state_mem #(
        .HIDDEN     (HIDDEN),
        .NUM_LAYERS (NUM_LAYERS)
    ) u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (init),
        .wr_en    (a_valid),
        .wr_layer (a_layer),
        .wr_idx   (a_idx),
        .wr_c     (calc_c),
        .wr_h     (calc_h),
        .rc_layer (in_layer),
        .rc_idx   (in_idx),
        .rc_c     (mem_c),
        .rh_layer (rd_layer),
        .rh_idx   (rd_idx),
        .rh_h     (rd_h)
    );

    logic [STEP_W-1:0] step_cnt;
    logic              last_elem;

    assign last_elem = a_valid && (a_idx == LAST_IDX) && (a_layer == LAST_LAYER);

    // stage B register: presented results
    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            out_valid <= 1'b0;
            out_layer <= '0;
            out_idx   <= '0;
            out_c     <= '0;
            out_h     <= '0;
        end else begin
            out_valid <= a_valid;
            if (a_valid) begin
                out_layer <= a_layer;
                out_idx   <= a_idx;
                out_c     <= calc_c;
                out_h     <= calc_h;
            end
        end
    end

    // step counter and end-of-sequence pulse
    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            step_cnt <= '0;
            seq_done <= 1'b0;
        end else begin
            seq_done <= 1'b0;
            if (last_elem) begin
                if (step_cnt == LAST_STEP) begin
                    step_cnt <= '0;
                    seq_done <= 1'b1;
                end else begin
                    step_cnt <= step_cnt + 1'b1;
                end
            end
        end
    end

    // ---------------- assertions ----------------
    // R1: activated gates stay in [0, 1]
    a_r1_gate_range: assert property (@(posedge clk) disable iff (!rst_n)
        a_valid |-> (a_act[G_IN]  >= 0 && a_act[G_IN]  <= Q_ONE &&
                     a_act[G_FGT] >= 0 && a_act[G_FGT] <= Q_ONE &&
                     a_act[G_OUT] >= 0 && a_act[G_OUT] <= Q_ONE));

    // R2: activated candidate stays in [-1, 1]
    a_r2_cand_range: assert property (@(posedge clk) disable iff (!rst_n)
        a_valid |-> (a_act[G_CAND] >= Q_NEG_ONE && a_act[G_CAND] <= Q_ONE));

    // R4: presented hidden value is bounded by one
    a_r4_h_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_h >= Q_NEG_ONE && out_h <= Q_ONE));

    // R6: a result needs an element accepted two edges earlier, no init since
    a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(in_valid, 2) && !$past(init, 1) && !$past(init, 2)));

    // R8: init leaves no result and zero state behind
    a_r8_init_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> (!out_valid && rd_h == 16'sd0));

    // R10: done only with the last element of the last layer
    a_r10_done_last: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> (out_valid && out_idx == LAST_IDX && out_layer == LAST_LAYER));

endmodule

// File: tb/sim_lstm_gate_update.sv
module sim_lstm_gate_update;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        init;
    logic        in_valid;
    logic [0:0]  in_layer;
    logic [4:0]  in_idx;
    logic signed [15:0] pre_i, pre_f, pre_o, pre_g;
    logic [0:0]  rd_layer;
    logic [4:0]  rd_idx;
    logic signed [15:0] rd_h;
    logic        out_valid;
    logic [0:0]  out_layer;
    logic [4:0]  out_idx;
    logic signed [15:0] out_c, out_h;
    logic        seq_done;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    lstm_gate_update u0 (
        .clk (clk), .rst_n (rst_n), .init (init),
        .in_valid (in_valid), .in_layer (in_layer), .in_idx (in_idx),
        .pre_i (pre_i), .pre_f (pre_f), .pre_o (pre_o), .pre_g (pre_g),
        .rd_layer (rd_layer), .rd_idx (rd_idx), .rd_h (rd_h),
        .out_valid (out_valid), .out_layer (out_layer), .out_idx (out_idx),
        .out_c (out_c), .out_h (out_h), .seq_done (seq_done)
    );

    // rows: pre_i, pre_f, pre_o, pre_g, expected c, expected h (element = row, layer 0, zero prior state)
    localparam logic [15:0] TV [6][6] = '{
        '{16'h7FFF, 16'h0000, 16'h7FFF, 16'h0800, 16'h0800, 16'h0800},
        '{16'h0000, 16'h0000, 16'h0000, 16'h1000, 16'h0800, 16'h0400},
        '{16'h8000, 16'h0000, 16'h7FFF, 16'h7FFF, 16'h0000, 16'h0000},
        '{16'h7FFF, 16'h0000, 16'h7FFF, 16'hC000, 16'hF000, 16'hF000},
        '{16'h0400, 16'h0000, 16'h1000, 16'h0800, 16'h0480, 16'h0360},
        '{16'h7FFF, 16'h0000, 16'h0000, 16'hFFFF, 16'hFFFF, 16'hFFFF}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic put(input int l, input int j, input logic [15:0] pi, input logic [15:0] pf,
                       input logic [15:0] po, input logic [15:0] pg);
        in_valid = 1'b1;
        in_layer = 1'(l);
        in_idx   = 5'(j);
        pre_i = pi; pre_f = pf; pre_o = po; pre_g = pg;
    endtask

    // one element; returns at the negedge where its result must be visible
    task automatic send_one(input int l, input int j, input logic [15:0] pi, input logic [15:0] pf,
                            input logic [15:0] po, input logic [15:0] pg);
        @(negedge clk);
        put(l, j, pi, pf, po, pg);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R6 no early result", 16'(out_valid), 16'h0000);
        @(negedge clk);
        chk("R6 result after second edge", 16'(out_valid), 16'h0001);
        chk("R6 index tag", 16'(out_idx), 16'(j));
    endtask

    task automatic read_h(input int l, input int j, input logic [15:0] exp, input string req);
        rd_layer = 1'(l);
        rd_idx   = 5'(j);
        #0.1;
        chk(req, rd_h, exp);
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    endtask

    // watchdog
    initial begin
        repeat (60000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
    end

    initial begin
        int outs, dones, done_at;
        rst_n = 1'b0; init = 1'b0; in_valid = 1'b0; in_layer = '0; in_idx = '0;
        pre_i = '0; pre_f = '0; pre_o = '0; pre_g = '0; rd_layer = '0; rd_idx = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk("R11 out_valid after reset", 16'(out_valid), 16'h0000);
        chk("R11 seq_done after reset", 16'(seq_done), 16'h0000);
        read_h(0, 0, 16'h0000, "R11 state zero after reset");
        read_h(1, 31, 16'h0000, "R11 state zero after reset");

        // table: R1 R2 R3 R4 on fresh slots
        for (int r = 0; r < 6; r++) begin
            send_one(0, r, TV[r][0], TV[r][1], TV[r][2], TV[r][3]);
            chk("R1 R2 R3 R5 vector cell", out_c, TV[r][4]);
            chk("R2 R4 vector hidden", out_h, TV[r][5]);
        end

        // R7 read port returns stored hidden values
        read_h(0, 4, 16'h0360, "R7 stored hidden layer0 elem4");
        read_h(1, 4, 16'h0000, "R7 other layer untouched");

        // R3 forget path on persistent state: f=0.5, i=0, c_old=0x0800
        send_one(0, 0, 16'h8000, 16'h0000, 16'h7FFF, 16'h0000);
        chk("R3 R7 forget-scaled cell", out_c, 16'h0400);
        chk("R4 hidden from forget path", out_h, 16'h0400);

        // R5 saturation: repeated +1.0 with f=1 on layer1 elem10
        for (int k = 1; k <= 9; k++) begin
            send_one(1, 10, 16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h1000);
            chk("R5 accumulating cell", out_c, (k >= 8) ? 16'h7FFF : 16'(4096 * k));
        end
        chk("R2 R4 hidden of saturated cell", out_h, 16'h1000);
        read_h(0, 10, 16'h0000, "R7 layer isolation");
        read_h(1, 10, 16'h1000, "R7 layer1 slot kept");

        // R8 element offered in the init cycle is dropped
        @(negedge clk);
        init = 1'b1;
        put(0, 5, TV[0][0], TV[0][1], TV[0][2], TV[0][3]);
        @(negedge clk);
        init = 1'b0; in_valid = 1'b0;
        chk("R8 no result for element with init", 16'(out_valid), 16'h0000);
        @(negedge clk);
        chk("R8 no result for element with init", 16'(out_valid), 16'h0000);
        read_h(0, 5, 16'h0000, "R8 dropped element not stored");
        read_h(0, 4, 16'h0000, "R8 old state cleared");
        read_h(1, 10, 16'h0000, "R8 old state cleared");

        // R8 element in flight when init arrives is dropped
        @(negedge clk);
        put(0, 6, TV[0][0], TV[0][1], TV[0][2], TV[0][3]);
        @(negedge clk);
        in_valid = 1'b0; init = 1'b1;
        @(negedge clk);
        init = 1'b0;
        chk("R8 in-flight result dropped", 16'(out_valid), 16'h0000);
        read_h(0, 6, 16'h0000, "R8 in-flight element not stored");

        // R9 back-to-back update of the same slot
        @(negedge clk);
        put(0, 20, 16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h1000);
        @(negedge clk);
        put(0, 20, 16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h1000);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R9 first update cell", out_c, 16'h1000);
        @(negedge clk);
        chk("R9 chained second update cell", out_c, 16'h2000);
        chk("R9 chained second update hidden", out_h, 16'h1000);

        // R10 with R8: advance the step count, then init must restart it
        send_one(1, 31, 16'h0000, 16'h0000, 16'h0000, 16'h0000);
        @(negedge clk);
        init = 1'b1;
        @(negedge clk);
        init = 1'b0;

        outs = 0; dones = 0; done_at = 0;
        for (int s = 0; s < 50; s++) begin
            for (int l = 0; l < 2; l++) begin
                for (int j = 0; j < 32; j++) begin
                    @(negedge clk);
                    if (out_valid) outs++;
                    if (seq_done) begin dones++; done_at = outs; end
                    put(l, j, 16'h0000, 16'h0000, 16'h0000, 16'h0000);
                end
            end
        end
        for (int t = 0; t < 4; t++) begin
            @(negedge clk);
            if (out_valid) outs++;
            if (seq_done) begin dones++; done_at = outs; end
            in_valid = 1'b0;
        end
        chk("R6 one result per element streamed", 16'(outs), 16'd3200);
        chk("R10 single done pulse", 16'(dones), 16'd1);
        chk("R10 R8 done on last element of step 50", 16'(done_at), 16'd3200);

        summary();
    end

endmodule